// File: doc/BRIEF.md
# Sequential-Aware DRAM Access Controller

This block sits between a processor and a DRAM whose row and column addresses share one set of address pins. Each processor cycle is either an internal cycle (no memory traffic) or a memory access with a word address, a read/write flag and a flag saying the address is one word past the previous one. The controller keeps one row open and remembers which row it is. A sequential access that lands in the open row is served by a single column strobe with no stall. Every other access closes the row, opens the new one and then strobes the column, stalling the processor through a wait output.

Addresses are pipelined: the processor puts the next address on the bus before the cycle that uses it, and the controller samples it at the clock edge that ends a cycle with wait low. During an internal cycle the bus already carries the upcoming access. If that access cannot be column-only, the controller closes the row during the idle cycle, so the precharge stall is gone when the access arrives. The byte offset within a word and the data lanes are handled outside this block. The DRAM itself is modelled by the bench.

Top module: `seqdram_ctrl`

## Requirements
- R1: While reset is asserted and on release, the row strobe, column strobe and write strobe (all active low) are high, wait is low and no row counts as open.
- R2: The multiplexed address carries the row field (word address bits [ADDR_W-1:COL_W]) in the cycle the row strobe falls, and the column field (word address bits [COL_W-1:0], zero-extended) in every cycle with the column strobe low. The column strobe is only ever low while the row strobe is low.
- R3: A memory access with the sequential flag high, whose row field equals the open row, is served in the next cycle with row strobe low, column strobe low and wait low.
- R4: A memory access that is not column-only while a row is open takes three cycles: precharge, row and column. Wait is high in the first two and low in the third, so wait is never high for more than two cycles in a row.
- R5: A memory access arriving with no row open takes two cycles: row strobe with wait high, then column strobe with wait low.
- R6: Before a different row is opened, the row strobe stays high for one full cycle with the column strobe high.
- R7: An internal cycle drives the column strobe high and wait low. If a row is open and the address and sequential flag on the bus would not give a column-only access, the row strobe goes high in that cycle and the row is closed.
- R8: An internal cycle whose bus contents would give a column-only access leaves the row strobe low and the row open.
- R9: The write strobe is low exactly in the column-strobe cycle of a write, and high in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | Word address of the next cycle |
| cpu_internal | input | 1 | High: internal cycle, no memory access |
| cpu_write | input | 1 | High: write access |
| cpu_seq | input | 1 | High: address is the previous one plus one word |
| dram_a | output | MUX_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| cpu_wait | output | 1 | High: processor must hold its request |

## Verification
The bench walks sequential addresses across two row boundaries. A controller that trusts the sequential flag without checking the row would put a column strobe on the wrong row at word 64. It also sends non-sequential accesses to the open row and sequential-flagged accesses that jump to another row. Both must take the full path: a design that ignores either condition would skip the precharge and the row cycle. Internal cycles are mixed in at random, with both hit and miss lookahead. A design that never closes the row early would stall twice after such a cycle. A design that always closes it would turn the following column-only access into a full one.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_INT  = 3'd1,
        ST_COL  = 3'd2,
        ST_PRE  = 3'd3,
        ST_ROW  = 3'd4
    } sdc_state_e;

endpackage

// File: rtl/sdc_addr_split.sv
module sdc_addr_split #(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 6,
    localparam int ROW_W = ADDR_W - COL_W
) (
    input  logic [ADDR_W-1:0] word_addr,
    output logic [ROW_W-1:0]  row_field,
    output logic [COL_W-1:0]  col_field
);
    assign col_field = word_addr[COL_W-1:0];
    assign row_field = word_addr[ADDR_W-1:COL_W];
endmodule

// File: rtl/sdc_hit_detect.sv
module sdc_hit_detect #(
    parameter int ROW_W = 8
) (
    input  logic             row_open,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] req_row,
    input  logic             seq_flag,
    output logic             col_only
);
    // column-only needs a sequential address and no row-boundary crossing
    assign col_only = row_open & seq_flag & (open_row == req_row);
endmodule

// File: rtl/sdc_mux_drive.sv
module sdc_mux_drive #(
    parameter int ROW_W = 8,
    parameter int COL_W = 6,
    parameter int MUX_W = 8
) (
    input  logic             sel_col,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    output logic [MUX_W-1:0] mux_out
);
    logic [MUX_W-1:0] row_ext;
    logic [MUX_W-1:0] col_ext;

    generate
        if (ROW_W == MUX_W) begin : g_row_full
            assign row_ext = row_in;
        end else begin : g_row_pad
            assign row_ext = {{(MUX_W-ROW_W){1'b0}}, row_in};
        end
        if (COL_W == MUX_W) begin : g_col_full
            assign col_ext = col_in;
        end else begin : g_col_pad
            assign col_ext = {{(MUX_W-COL_W){1'b0}}, col_in};
        end
    endgenerate

    assign mux_out = sel_col ? col_ext : row_ext;
endmodule

// File: rtl/seqdram_ctrl.sv
module seqdram_ctrl #(
    parameter int  ADDR_W = 14,
    parameter int  COL_W  = 6,
    localparam int ROW_W  = ADDR_W - COL_W,
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_internal,
    input  logic              cpu_write,
    input  logic              cpu_seq,
    output logic [MUX_W-1:0]  dram_a,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              cpu_wait
);
    import sdc_pkg::*;

    typedef struct packed {
        sdc_state_e       st;
        logic             row_open;
        logic [ROW_W-1:0] open_row;
        logic [ROW_W-1:0] pend_row;
        logic [COL_W-1:0] pend_col;
        logic             pend_wr;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             wait_o;
        logic [MUX_W-1:0] a;
    } regs_t;

    regs_t q, d;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             hit;
    logic [MUX_W-1:0] req_mux;
    logic [MUX_W-1:0] pend_mux;
    logic             accept;

    sdc_addr_split #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_split (
        .word_addr (cpu_addr),
        .row_field (req_row),
        .col_field (req_col)
    );

    sdc_hit_detect #(.ROW_W(ROW_W)) u_hit (
        .row_open (q.row_open),
        .open_row (q.open_row),
        .req_row  (req_row),
        .seq_flag (cpu_seq),
        .col_only (hit)
    );

    // request path: column on a hit, row when opening a closed row
    sdc_mux_drive #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_req_mux (
        .sel_col (hit),
        .row_in  (req_row),
        .col_in  (req_col),
        .mux_out (req_mux)
    );

    // pending path: row after precharge, column after row
    sdc_mux_drive #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_pend_mux (
        .sel_col (q.st == ST_ROW),
        .row_in  (q.pend_row),
        .col_in  (q.pend_col),
        .mux_out (pend_mux)
    );

    // a new request is taken at the end of every cycle without a stall
    assign accept = ~q.wait_o;

    always_comb begin
        d        = q;
        d.cas_n  = 1'b1;
        d.we_n   = 1'b1;
        d.wait_o = 1'b0;
        if (accept) begin
            if (cpu_internal) begin
                // idle cycle: bus already shows the next access
                d.st = ST_INT;
                if (q.row_open && !hit) begin
                    d.ras_n    = 1'b1;
                    d.row_open = 1'b0;
                end
            end else if (hit) begin
                d.st    = ST_COL;
                d.ras_n = 1'b0;
                d.cas_n = 1'b0;
                d.we_n  = ~cpu_write;
                d.a     = req_mux;
            end else begin
                d.pend_row = req_row;
                d.pend_col = req_col;
                d.pend_wr  = cpu_write;
                d.wait_o   = 1'b1;
                if (q.row_open) begin
                    d.st       = ST_PRE;
                    d.ras_n    = 1'b1;
                    d.row_open = 1'b0;
                end else begin
                    d.st       = ST_ROW;
                    d.ras_n    = 1'b0;
                    d.row_open = 1'b1;
                    d.open_row = req_row;
                    d.a        = req_mux;
                end
            end
        end else begin
            case (q.st)
                ST_PRE: begin
                    d.st       = ST_ROW;
                    d.ras_n    = 1'b0;
                    d.row_open = 1'b1;
                    d.open_row = q.pend_row;
                    d.a        = pend_mux;
                    d.wait_o   = 1'b1;
                end
                ST_ROW: begin
                    d.st    = ST_COL;
                    d.ras_n = 1'b0;
                    d.cas_n = 1'b0;
                    d.we_n  = ~q.pend_wr;
                    d.a     = pend_mux;
                end
                default: begin
                    d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.row_open <= 1'b0;
            q.open_row <= '0;
            q.pend_row <= '0;
            q.pend_col <= '0;
            q.pend_wr  <= 1'b0;
            q.ras_n    <= 1'b1;
            q.cas_n    <= 1'b1;
            q.we_n     <= 1'b1;
            q.wait_o   <= 1'b0;
            q.a        <= '0;
        end else begin
            q <= d;
        end
    end

    assign dram_a     = q.a;
    assign dram_ras_n = q.ras_n;
    assign dram_cas_n = q.cas_n;
    assign dram_we_n  = q.we_n;
    assign cpu_wait   = q.wait_o;

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
    input logic clk,
    input logic rst_n,
    input logic cpu_internal,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n,
    input logic cpu_wait
);
    assert_cas_under_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    assert_row_then_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && dram_cas_n && cpu_wait) |=> (!dram_cas_n && !cpu_wait));

    assert_row_open_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (cpu_wait && dram_cas_n));

    assert_wait_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && $past(cpu_wait)) |=> !cpu_wait);

    assert_precharge_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n && cpu_wait) |=> (!dram_ras_n && cpu_wait));

    assert_internal_no_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wait && !$past(cpu_wait) && $past(cpu_internal)) |-> dram_cas_n);

    assert_we_in_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> !dram_cas_n);
endmodule

bind seqdram_ctrl sdc_checker u_sdc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_internal (cpu_internal),
    .dram_ras_n   (dram_ras_n),
    .dram_cas_n   (dram_cas_n),
    .dram_we_n    (dram_we_n),
    .cpu_wait     (cpu_wait)
);

// File: tb/tb_seqdram_ctrl.sv
module tb_seqdram_ctrl;
    localparam int ADDR_W = 14;
    localparam int COL_W  = 6;
    localparam int ROW_W  = ADDR_W - COL_W;
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_internal = 1'b1;
    logic              cpu_write = 1'b0;
    logic              cpu_seq = 1'b0;
    logic [MUX_W-1:0]  dram_a;
    logic              dram_ras_n, dram_cas_n, dram_we_n, cpu_wait;

    int total = 0;
    int bad   = 0;

    // bench model of the open row
    bit                m_open = 0;
    logic [ROW_W-1:0]  m_row  = '0;
    logic [ADDR_W-1:0] m_prev = '0;
    logic [15:0]       lfsr   = 16'hACE1;

    always #4 clk = ~clk;

    seqdram_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_internal(cpu_internal),
        .cpu_write(cpu_write), .cpu_seq(cpu_seq), .dram_a(dram_a),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .cpu_wait(cpu_wait)
    );

    task automatic check_now(input string tag, input logic [3:0] exp_ctl,
                             input bit chk_a, input logic [MUX_W-1:0] exp_a);
        logic [3:0] act_ctl;
        act_ctl = {dram_ras_n, dram_cas_n, dram_we_n, cpu_wait};
        total++;
        if (act_ctl !== exp_ctl || (chk_a && dram_a !== exp_a)) begin
            bad++;
            $display("FAIL %s: ras/cas/we/wait=%b a=%h expected %b a=%h",
                     tag, act_ctl, dram_a, exp_ctl, exp_a);
        end
    endtask

    task automatic step_check(input string tag, input logic [3:0] exp_ctl,
                              input bit chk_a, input logic [MUX_W-1:0] exp_a);
        @(posedge clk);
        @(negedge clk);
        check_now(tag, exp_ctl, chk_a, exp_a);
    endtask

    function automatic logic [MUX_W-1:0] row_of(input logic [ADDR_W-1:0] wa);
        return MUX_W'(wa[ADDR_W-1:COL_W]);
    endfunction

    function automatic logic [MUX_W-1:0] col_of(input logic [ADDR_W-1:0] wa);
        return MUX_W'(wa[COL_W-1:0]);
    endfunction

    // one processor cycle; called at a falling edge, returns at a falling edge
    task automatic run_cycle(input bit intl, input bit wr, input bit seq,
                             input logic [ADDR_W-1:0] wa);
        bit hit;
        logic [ROW_W-1:0] r;
        r   = wa[ADDR_W-1:COL_W];
        hit = m_open && seq && (r == m_row);
        cpu_internal = intl;
        cpu_write    = wr;
        cpu_seq      = seq;
        cpu_addr     = wa;
        if (intl) begin
            if (m_open && !hit) begin
                m_open = 0;
                step_check("R7", 4'b1110, 1'b0, '0);
            end else if (m_open) begin
                step_check("R8", 4'b0110, 1'b0, '0);
            end else begin
                step_check("R7", 4'b1110, 1'b0, '0);
            end
        end else begin
            if (hit) begin
                step_check("R3/R9", {2'b00, ~wr, 1'b0}, 1'b1, col_of(wa));
            end else begin
                if (m_open) step_check("R6/R4", 4'b1111, 1'b0, '0);
                else        step_check("R5", 4'b0111, 1'b1, row_of(wa));
                if (m_open) step_check("R2/R4", 4'b0111, 1'b1, row_of(wa));
                step_check("R2/R9", {2'b00, ~wr, 1'b0}, 1'b1, col_of(wa));
                m_open = 1;
                m_row  = r;
            end
            m_prev = wa;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_now("R1", 4'b1110, 1'b0, '0);
        rst_n = 1'b1;
        check_now("R1", 4'b1110, 1'b0, '0);
        // first access, no row open
        run_cycle(0, 0, 0, 14'd0);
        // sequential walk across two row boundaries, alternating writes
        for (int i = 1; i <= 140; i++) begin
            run_cycle(0, i[0], 1, ADDR_W'(i));
        end
        // non-sequential, same row
        run_cycle(0, 0, 0, m_prev + 1'b1);
        // sequential flag with a jump to another row
        run_cycle(0, 1, 1, m_prev + 14'd200);
        // internal cycle ahead of a sequential hit, then a miss
        run_cycle(1, 0, 1, m_prev + 1'b1);
        run_cycle(0, 0, 1, m_prev + 1'b1);
        run_cycle(1, 1, 0, 14'h1234);
        run_cycle(0, 1, 0, 14'h1234);
        // mixed sweep
        for (int k = 0; k < 800; k++) begin
            bit seq;
            bit wr;
            logic [ADDR_W-1:0] nxt;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            seq  = lfsr[2] | lfsr[3];
            wr   = lfsr[4];
            nxt  = seq ? m_prev + 1'b1 : lfsr[ADDR_W+1:2];
            if (lfsr[0] & lfsr[1]) run_cycle(1, wr, seq, nxt);
            run_cycle(0, wr, seq, nxt);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule